// File: doc/BRIEF.md
# Edge-Qualified Retriggerable One-Shot Timer

This block is a clocked monostable. Two trigger inputs have opposite edge senses. A rising edge on `trig_a` fires only while `trig_b` is high, and a falling edge on `trig_b` fires only while `trig_a` is low. A qualified edge sets the true output `q` high for a pulse whose length is set in clock cycles. The inverted output `qn` mirrors it. The length of the trigger level has no effect on the pulse.

Each firing starts with a fixed lockout window of `LOCK_CYCLES` clock cycles, during which any further trigger is dropped. After that window the timing interval of `pulse_cycles` cycles runs. With `retrig_en` high, a qualified edge during the timing interval restarts the whole sequence, which stretches the pulse. With `retrig_en` low, the block ignores all edges while `q` is high.

An asynchronous active-low clear cancels the pulse at once. A synchronous power-on reset holds the block in a quiet lockout for `INIT_CYCLES` cycles before it accepts triggers.

Top module: `osh_oneshot`

## Requirements
- R1: A rising edge on `trig_a` while `trig_b` is high starts a pulse. `q` goes high just after the third rising clock edge, counting the edge that first samples the new input level as the first.
- R2: A rising edge on `trig_a` while `trig_b` is low does not start a pulse.
- R3: A falling edge on `trig_b` while `trig_a` is low starts a pulse with the same latency as R1. A falling edge on `trig_b` while `trig_a` is high does not start a pulse.
- R4: A pulse that is not retriggered keeps `q` high for exactly `LOCK_CYCLES + pulse_cycles` clock cycles, however long the trigger input is held.
- R5: A `pulse_cycles` value of 0 acts as 1, so the pulse lasts `LOCK_CYCLES + 1` cycles.
- R6: A qualified edge detected during the first `LOCK_CYCLES` cycles of a pulse is ignored and leaves the pulse length unchanged.
- R7: With `retrig_en` = 1, a qualified edge detected after the lockout window, while `q` is still high, restarts the sequence. `q` then stays high until `LOCK_CYCLES + pulse_cycles` cycles after that detection.
- R8: With `retrig_en` = 0, every edge while `q` is high is ignored, and the pulse ends on its original schedule.
- R9: While `clear_n` is low, `q` is 0 and `qn` is 1 with no clock edge needed. A pulse in progress is cancelled and does not resume after release. Release returns the block to idle, ready for the next edge, and also ends any power-on lockout.
- R10: While `rst` is high, and for `INIT_CYCLES` clock cycles after it falls, `q` stays 0, `qn` stays 1, and qualified edges are ignored.
- R11: `qn` is always the logical inverse of `q`.
- R12: `pulse_cycles` is sampled in the cycle the trigger is accepted. Changing it later has no effect on the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; starts the power-on lockout |
| clear_n | input | 1 | Asynchronous active-low clear; cancels the pulse |
| trig_a | input | 1 | Rising-edge trigger, qualified by `trig_b` high |
| trig_b | input | 1 | Falling-edge trigger, qualified by `trig_a` low |
| retrig_en | input | 1 | 1: edges after the lockout restart the pulse; 0: edges ignored while `q` is high |
| pulse_cycles | input | WIDTH | Timing interval in clock cycles, sampled at trigger; 0 acts as 1 |
| q | output | 1 | Pulse output, rests low |
| qn | output | 1 | Inverse of `q` |

## Verification
The bench targets several corner cases, and each has a distinct failure signature.

- **Edge qualification.** The bench moves both trigger inputs in the same cycle, and also makes edges against the wrong level of the other input. Wrong qualification shows up as an extra pulse.
- **Lockout and retrigger.** The bench places a second edge inside the lockout and a third one after it. A design that restarts during the lockout gives a longer pulse. A design that ignores the late edge, or that retriggers with `retrig_en` low, ends the pulse on the wrong cycle.
- **Pulse length and sampling.** A zero `pulse_cycles`, a change of `pulse_cycles` in mid-pulse, and a one-cycle trigger each expose latching faults through the measured length.
- **Clear and power-on lockout.** The asynchronous clear is checked before any clock edge, and again for a pulse that must not come back after release. Edges during the power-on lockout must produce no pulse.

A long random run compares `q` cycle by cycle with a bench model built from these rules.

// File: rtl/osh_pkg.sv
package osh_pkg;

    // Sequencer phases. Only LOCK and TIME drive the output high.
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_LOCK = 2'd2,
        ST_TIME = 2'd3
    } osh_state_e;

    // Synchronised trigger pair.
    typedef struct packed {
        logic b;
        logic a;
    } osh_pair_t;

    // Bits needed to hold the values 0 .. n-1.
    function automatic int unsigned osh_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned osh_max3(input int unsigned x,
                                             input int unsigned y,
                                             input int unsigned z);
        int unsigned m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction

    function automatic logic osh_is_active(input osh_state_e s);
        return (s == ST_LOCK) || (s == ST_TIME);
    endfunction

endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned N      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/osh_edge_qual.sv
module osh_edge_qual
    import osh_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a_raw,
    input  logic b_raw,
    output logic trig
);
    osh_pair_t now_s;
    osh_pair_t prev_s;
    osh_pair_t raw_p;
    logic      a_rise;
    logic      b_fall;

    assign raw_p = '{b: b_raw, a: a_raw};

    osh_sync #(
        .STAGES(SYNC_STAGES),
        .N     (2)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_p),
        .q  (now_s)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_s <= '0;
        else     prev_s <= now_s;
    end

    // The other input's level is taken from the same synchronised sample.
    assign a_rise = now_s.a & ~prev_s.a;
    assign b_fall = ~now_s.b & prev_s.b;
    assign trig   = (a_rise & now_s.b) | (b_fall & ~now_s.a);
endmodule

// File: rtl/osh_seq.sv
module osh_seq
    import osh_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned LOCK_CYCLES = 4,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             trig,
    input  logic             retrig_en,
    input  logic [WIDTH-1:0] pulse_cycles,
    output osh_state_e       st,
    output logic             active
);
    localparam int unsigned CW = osh_max3(WIDTH, osh_bits(LOCK_CYCLES), osh_bits(INIT_CYCLES));
    localparam logic [CW-1:0] LOCK_LOAD = CW'(LOCK_CYCLES - 1);
    localparam logic [CW-1:0] INIT_LOAD = CW'(INIT_CYCLES - 1);

    typedef struct packed {
        osh_state_e       st;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] len;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{st: ST_IDLE, cnt: '0, len: '0};
    localparam ctl_t CTL_INIT = '{st: ST_INIT, cnt: INIT_LOAD, len: '0};

    ctl_t             ctl;
    ctl_t             nxt;
    ctl_t             armed;
    logic [WIDTH-1:0] eff_len;
    logic             cnt_done;

    assign eff_len  = (pulse_cycles == '0) ? WIDTH'(1) : pulse_cycles;
    assign armed    = '{st: ST_LOCK, cnt: LOCK_LOAD, len: eff_len};
    assign cnt_done = (ctl.cnt == '0);

    always_comb begin
        nxt = ctl;
        unique case (ctl.st)
            ST_INIT: begin
                if (cnt_done) nxt.st  = ST_IDLE;
                else          nxt.cnt = ctl.cnt - CW'(1);
            end
            ST_IDLE: begin
                if (trig) nxt = armed;
            end
            ST_LOCK: begin
                if (cnt_done) begin
                    nxt.st  = ST_TIME;
                    nxt.cnt = CW'(ctl.len) - CW'(1);
                end else begin
                    nxt.cnt = ctl.cnt - CW'(1);
                end
            end
            ST_TIME: begin
                if (trig && retrig_en) nxt     = armed;
                else if (cnt_done)     nxt.st  = ST_IDLE;
                else                   nxt.cnt = ctl.cnt - CW'(1);
            end
            default: nxt = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)  ctl <= CTL_IDLE;
        else if (rst)  ctl <= CTL_INIT;
        else           ctl <= nxt;
    end

    assign st     = ctl.st;
    assign active = osh_is_active(ctl.st);
endmodule

// File: rtl/osh_oneshot.sv
module osh_oneshot
    import osh_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned LOCK_CYCLES = 4,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic             retrig_en,
    input  logic [WIDTH-1:0] pulse_cycles,
    output logic             q,
    output logic             qn
);
    logic       trig_w;
    logic       active_w;
    osh_state_e st_w;

    osh_edge_qual #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk  (clk),
        .rst  (rst),
        .a_raw(trig_a),
        .b_raw(trig_b),
        .trig (trig_w)
    );

    osh_seq #(
        .WIDTH      (WIDTH),
        .LOCK_CYCLES(LOCK_CYCLES),
        .INIT_CYCLES(INIT_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .clear_n     (clear_n),
        .trig        (trig_w),
        .retrig_en   (retrig_en),
        .pulse_cycles(pulse_cycles),
        .st          (st_w),
        .active      (active_w)
    );

    // Clear gates the output directly, so it takes effect without a clock edge.
    assign q  = active_w & clear_n;
    assign qn = ~q;
endmodule

// File: rtl/osh_oneshot_chk.sv
module osh_oneshot_chk
    import osh_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 4,
    parameter int unsigned INIT_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       clear_n,
    input logic       trig,
    input logic       retrig_en,
    input osh_state_e st,
    input logic       q,
    input logic       qn
);
    localparam int unsigned LW = $clog2(LOCK_CYCLES + 2);
    localparam int unsigned SW = $clog2(INIT_CYCLES + 2);

    logic [LW-1:0] lock_run;
    logic [SW-1:0] since_rst;
    logic          seen_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_run  <= '0;
            since_rst <= '0;
        end else begin
            if (st == ST_LOCK) begin
                if (lock_run != LW'(LOCK_CYCLES + 1)) lock_run <= lock_run + LW'(1);
            end else begin
                lock_run <= '0;
            end
            if (since_rst != SW'(INIT_CYCLES + 1)) since_rst <= since_rst + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) seen_clear <= 1'b1;
        else if (rst) seen_clear <= 1'b0;
    end

    // R11
    a_r11_qn_inverse: assert property (@(posedge clk) disable iff (rst)
        qn == ~q);

    // R9
    a_r9_clear_output_low: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> (!q && qn));

    // R10
    a_r10_power_on_quiet: assert property (@(posedge clk) disable iff (rst)
        (!seen_clear && (since_rst <= SW'(INIT_CYCLES))) |-> !q);

    // R6
    a_r6_lock_not_extended: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (st == ST_LOCK) |-> (lock_run < LW'(LOCK_CYCLES)));

    // R1
    a_r1_idle_trigger_starts: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (st == ST_IDLE && trig) |=> q);

    // R7
    a_r7_retrig_restarts: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (st == ST_TIME && trig && retrig_en) |=> (st == ST_LOCK));

    // R8
    a_r8_no_retrig_when_off: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (st == ST_TIME && trig && !retrig_en) |=> (st != ST_LOCK));
endmodule

bind osh_oneshot osh_oneshot_chk #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .INIT_CYCLES(INIT_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clear_n  (clear_n),
    .trig     (trig_w),
    .retrig_en(retrig_en),
    .st       (st_w),
    .q        (q),
    .qn       (qn)
);

// File: tb/sim_osh_oneshot.sv
`timescale 1ns/1ps
module sim_osh_oneshot;
    localparam int W = 8;
    localparam int L = 4;
    localparam int I = 8;

    logic         clk     = 1'b0;
    logic         rst     = 1'b1;
    logic         clear_n = 1'b1;
    logic         a       = 1'b0;
    logic         b       = 1'b0;
    logic         retrig  = 1'b1;
    logic [W-1:0] pulse   = W'(5);
    logic         q;
    logic         qn;

    always #2.5 clk = ~clk;

    osh_oneshot #(
        .WIDTH      (W),
        .LOCK_CYCLES(L),
        .INIT_CYCLES(I),
        .SYNC_STAGES(2)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .clear_n     (clear_n),
        .trig_a      (a),
        .trig_b      (b),
        .retrig_en   (retrig),
        .pulse_cycles(pulse),
        .q           (q),
        .qn          (qn)
    );

    int   checks = 0, failures = 0, cyc = 0;
    int   rise_at = 0, fall_at = 0, npulse = 0, inv_bad = 0;
    logic q_prev = 1'b0;
    bit   cmp_on = 1'b0;
    bit   done   = 1'b0;

    // reference model state (derived from the requirements)
    logic h1a = 0, h2a = 0, h3a = 0, h1b = 0, h2b = 0, h3b = 0;
    int   rem = 0, lk = 0, initl = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        logic trg;
        int   w;
        cyc++;
        trg = (h2a & ~h3a & h2b) | (~h2b & h3b & ~h2a);
        w   = (pulse == 0) ? 1 : int'(pulse);
        if (!clear_n) begin
            rem = 0; lk = 0; initl = 0;
        end else if (rst) begin
            rem = 0; lk = 0; initl = I;
        end else if (initl > 0) begin
            initl--;
        end else if (rem == 0) begin
            if (trg) begin rem = L + w; lk = L; end
        end else if (lk == 0 && trg && retrig) begin
            rem = L + w; lk = L;
        end else begin
            rem--;
            if (lk > 0) lk--;
        end
        if (rst) begin
            {h1a, h2a, h3a, h1b, h2b, h3b} = '0;
        end else begin
            h3a = h2a; h2a = h1a; h1a = a;
            h3b = h2b; h2b = h1b; h1b = b;
        end
        #1;
        if (q && !q_prev) begin rise_at = cyc; npulse++; end
        if (!q && q_prev) fall_at = cyc;
        q_prev = q;
        if (qn !== ~q) inv_bad++;
        if (cmp_on) chk("R1/R4/R6/R7/R8 model q", int'(q), int'(rem > 0 && clear_n));
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 30000 && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 30000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c0, c1, n0;
        void'($urandom(32'd7351));
        wait_n(4);
        chk("R10 q in reset", int'(q), 0);
        chk("R10 qn in reset", int'(qn), 1);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R10: edge inside the power-on lockout
        @(negedge clk) b = 1'b1;
        @(negedge clk) a = 1'b1;
        wait_n(20);
        chk("R10 lockout edge ignored", npulse, 0);
        a = 1'b0;
        wait_n(4);

        // R1 / R4
        n0 = npulse;
        @(negedge clk) a = 1'b1; c0 = cyc;
        wait_n(20);
        chk("R1 rise latency", rise_at, c0 + 3);
        chk("R4 length held trigger", fall_at - rise_at, L + 5);
        chk("R1 pulse count", npulse, n0 + 1);
        a = 1'b0;
        wait_n(4);

        // R2 / R3 negative cases
        n0 = npulse;
        @(negedge clk) begin a = 1'b1; b = 1'b0; end
        wait_n(3); a = 1'b0;
        wait_n(3); a = 1'b1;            // R2: rise while b low
        wait_n(15);
        chk("R2 a rise with b low", npulse, n0);
        b = 1'b1; wait_n(3);
        b = 1'b0;                       // R3: fall while a high
        wait_n(15);
        chk("R3 b fall with a high", npulse, n0);
        a = 1'b0; wait_n(3);
        b = 1'b1; wait_n(3);
        // R3 positive
        pulse = W'(3);
        @(negedge clk) b = 1'b0; c0 = cyc;
        wait_n(15);
        chk("R3 rise latency", rise_at, c0 + 3);
        chk("R3 length", fall_at - rise_at, L + 3);
        chk("R3 pulse count", npulse, n0 + 1);

        // R4: one-cycle trigger
        b = 1'b1; wait_n(3);
        pulse = W'(10);
        @(negedge clk) a = 1'b1; c0 = cyc;
        @(negedge clk) a = 1'b0;
        wait_n(20);
        chk("R4 short trigger rise", rise_at, c0 + 3);
        chk("R4 short trigger length", fall_at - rise_at, L + 10);

        // R5: zero width
        pulse = W'(0);
        @(negedge clk) a = 1'b1;
        @(negedge clk) a = 1'b0;
        wait_n(12);
        chk("R5 zero width", fall_at - rise_at, L + 1);

        // R12: width change mid-pulse
        pulse = W'(6);
        @(negedge clk) a = 1'b1;
        @(negedge clk) a = 1'b0;
        wait_n(4); pulse = W'(20);
        wait_n(15);
        chk("R12 width sampled at trigger", fall_at - rise_at, L + 6);

        // R6: second edge inside lockout
        pulse = W'(8);
        n0 = npulse;
        @(negedge clk) a = 1'b1; c0 = cyc;
        @(negedge clk) a = 1'b0;
        @(negedge clk) a = 1'b1;
        wait_n(20); a = 1'b0;
        chk("R6 lockout edge ignored length", fall_at - rise_at, L + 8);
        chk("R6 single pulse", npulse, n0 + 1);
        wait_n(3);

        // R7: retrigger after lockout
        retrig = 1'b1; pulse = W'(10);
        n0 = npulse;
        @(negedge clk) a = 1'b1; c0 = cyc;
        @(negedge clk) a = 1'b0;
        while (cyc < c0 + 7) @(negedge clk);
        a = 1'b1; c1 = cyc;
        wait_n(30); a = 1'b0;
        chk("R7 rise", rise_at, c0 + 3);
        chk("R7 stretched fall", fall_at, c1 + 3 + L + 10);
        chk("R7 single pulse", npulse, n0 + 1);
        wait_n(3);

        // R8: retrigger disabled
        retrig = 1'b0;
        n0 = npulse;
        @(negedge clk) a = 1'b1; c0 = cyc;
        @(negedge clk) a = 1'b0;
        while (cyc < c0 + 7) @(negedge clk);
        a = 1'b1;
        wait_n(30); a = 1'b0;
        chk("R8 original fall", fall_at, c0 + 3 + L + 10);
        chk("R8 single pulse", npulse, n0 + 1);
        retrig = 1'b1;
        wait_n(3);

        // R9: clear mid-pulse
        pulse = W'(20);
        n0 = npulse;
        @(negedge clk) a = 1'b1; c0 = cyc;
        @(negedge clk) a = 1'b0;
        while (cyc < c0 + 8) @(negedge clk);
        clear_n = 1'b0;
        #1;
        chk("R9 q immediate", int'(q), 0);
        chk("R9 qn immediate", int'(qn), 1);
        wait_n(2); clear_n = 1'b1;
        wait_n(30);
        chk("R9 cancelled fall", fall_at, c0 + 9);
        chk("R9 no resume", npulse, n0 + 1);
        pulse = W'(2);
        @(negedge clk) a = 1'b1;
        @(negedge clk) a = 1'b0;
        wait_n(12);
        chk("R9 idle after release", fall_at - rise_at, L + 2);
        chk("R9 pulse after release", npulse, n0 + 2);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 3 == 0) a = ~a;
            if ($urandom % 3 == 0) b = ~b;
            if ($urandom % 16 == 0) pulse = W'($urandom % 13);
            if ($urandom % 50 == 0) retrig = ~retrig;
            if (!clear_n) clear_n = 1'b1;
            else if ($urandom % 97 == 0) clear_n = 1'b0;
        end
        clear_n = 1'b1;
        wait_n(4);
        chk("R11 qn inverse mismatches", inv_bad, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule